// File: doc/BRIEF.md
# Two-Phase Microcoded Nibble Processor Core

This core is a small processor with separate program and data spaces and a single 4-bit accumulator. Program bytes come in on a 12-bit-addressed byte port. Nibble-wide data memory sits on its own 12-bit-addressed port. Every instruction takes exactly two clocks. In the fetch phase the program byte is latched into a Fetch register and the program counter advances. In the execute phase the instruction's control word steers the ALU, the flags, the data memory, the 4-bit I/O port and the program counter.

The core holds no decode logic of its own. It presents a 7-bit control-store index built from the opcode, the phase bit and the two flags, and an external store returns a 13-bit control word in the same cycle. Conditional jumps therefore resolve only by which word the store returns. Every memory port, including the control store, answers combinationally within the cycle. There is no valid/ready handshake and no back-pressure: the core never stalls and assumes every read completes in the cycle it is asked.

Data memory is enabled only while the clock is low. The write is committed by the memory at the rising edge that closes the execute phase, and address and data are held steady up to that edge.

Top module: `nib_core`

## Requirements
- R1: `uc_addr` is {opcode = Fetch[7:4] in bits 6:3, phase in bit 2, carry in bit 1, zero in bit 0}. Phase is 0 in the fetch clock and 1 in the execute clock. The control word bits are: 0 fetch-load, 1 pc-increment, 2 pc-load, 3 acc-load, 4 zero-load, 6:5 ALU op, 8:7 operand source, 9 data-memory enable, 10 data-memory write, 11 output-load, 12 carry-load.
- R2: In the fetch phase the program byte at `prog_addr` is latched into Fetch, `prog_addr` advances by one modulo 4096, and the accumulator does not change.
- R3: The data address is {Fetch[3:0], program byte presented in the execute phase}. Two-byte instructions advance the PC a second time in the execute phase.
- R4: The ALU op codes are 0 pass operand, 1 add, 2 subtract (accumulator minus operand, carry set when no borrow occurs), and 3 NOR. An add sets carry to the carry out of bit 3.
- R5: On zero-load, the zero flag becomes 1 exactly when the 4-bit ALU result is 0. Carry changes only on carry-load. A compare updates the flags and leaves the accumulator unchanged.
- R6: `dmem_ce_n` is low only while the clock is low and the enable bit is set. `dmem_we_n` is low when the write bit is set. The write data is the accumulator, stable through the execute phase.
- R7: The immediate operand (source 0) is Fetch[3:0]. Single-byte instructions do not advance the PC in the execute phase.
- R8: On pc-load the PC takes {Fetch[3:0], program byte}, giving a full 12-bit jump target.
- R9: Reset (`rst_n` low) clears the PC, the phase, Fetch, the accumulator, both flags and the output register.
- R10: On output-load the output register takes the accumulator. Operand source 2 selects `in_port`, source 1 selects data memory, and source 3 selects zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also gates data-memory enable |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_addr | output | 12 | Program counter to program memory |
| prog_data | input | 8 | Program byte at `prog_addr` |
| uc_addr | output | 7 | Control-store index |
| uc_word | input | 13 | Control word for `uc_addr` |
| dmem_addr | output | 12 | Data memory address |
| dmem_wdata | output | 4 | Data memory write nibble (accumulator) |
| dmem_rdata | input | 4 | Data memory read nibble |
| dmem_ce_n | output | 1 | Data memory chip enable, active low |
| dmem_we_n | output | 1 | Data memory write enable, active low |
| in_port | input | 4 | Input port nibble |
| out_port | output | 4 | Output register |

## Verification
The assertions rely on a well-formed control store. Every phase-0 word must load Fetch and advance the PC, and must not load the accumulator or use memory. The bench builds its whole control store from one generator that meets this for all opcode and flag combinations. The program bytes, data contents and input-port values are random, so they steer only which execute-phase words are chosen and never the fetch behaviour. The input port changes only at the start of an instruction, so it is stable whenever an execute phase reads it.

// File: rtl/nib_core_pkg.sv
package nib_core_pkg;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_SUB  = 2'd2,
    ALU_NOR  = 2'd3
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_IMM  = 2'd0,
    SRC_MEM  = 2'd1,
    SRC_PORT = 2'd2,
    SRC_NONE = 2'd3
  } opnd_src_e;

  // 13-bit control word, most significant field first
  typedef struct packed {
    logic      carry_ld;
    logic      out_ld;
    logic      mem_wr;
    logic      mem_en;
    opnd_src_e src;
    alu_op_e   alu;
    logic      zero_ld;
    logic      acc_ld;
    logic      pc_ld;
    logic      pc_inc;
    logic      fetch_ld;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/nib_alu.sv
module nib_alu
  import nib_core_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         cout
);

  logic [W:0] sum_w;
  logic [W:0] dif_w;

  assign sum_w = {1'b0, a} + {1'b0, b};
  // two's complement subtract; top bit set means no borrow
  assign dif_w = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};

  always_comb begin
    case (op)
      ALU_PASS: begin y = b;           cout = 1'b0;     end
      ALU_ADD:  begin y = sum_w[W-1:0]; cout = sum_w[W]; end
      ALU_SUB:  begin y = dif_w[W-1:0]; cout = dif_w[W]; end
      default:  begin y = ~(a | b);    cout = 1'b0;     end
    endcase
  end

endmodule

// File: rtl/nib_seq.sv
module nib_seq #(
  parameter int PW = 8,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_ld,
  input  logic          pc_inc,
  input  logic          pc_ld,
  input  logic [PW-1:0] prog_byte,
  output logic [AW-1:0] pc,
  output logic          phase,
  output logic [PW-1:0] fetch
);

  localparam int HI_W = AW - PW;
  localparam logic [AW-1:0] PC_ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] pc_q;
  logic          phase_q;
  logic [PW-1:0] fetch_q;
  logic [AW-1:0] target;

  assign target = {fetch_q[HI_W-1:0], prog_byte};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= '0;
      phase_q <= 1'b0;
      fetch_q <= '0;
    end else begin
      phase_q <= ~phase_q;
      if (fetch_ld) fetch_q <= prog_byte;
      if (pc_ld)       pc_q <= target;
      else if (pc_inc) pc_q <= pc_q + PC_ONE;
    end
  end

  assign pc    = pc_q;
  assign phase = phase_q;
  assign fetch = fetch_q;

  // fetch clock always advances the program counter by one
  assert_fetch_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_q |=> (pc_q == $past(pc_q) + PC_ONE));

  // a jump lands on the full 12-bit target
  assert_jump_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q && pc_ld) |=> (pc_q == $past(target)));

endmodule

// File: rtl/nib_datapath.sv
module nib_datapath
  import nib_core_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase,
  input  logic          acc_ld,
  input  logic          zero_ld,
  input  logic          carry_ld,
  input  logic          out_ld,
  input  alu_op_e       alu_op,
  input  opnd_src_e     src,
  input  logic [DW-1:0] imm,
  input  logic [DW-1:0] mem_rd,
  input  logic [DW-1:0] port_in,
  output logic [DW-1:0] acc,
  output logic          carry,
  output logic          zero,
  output logic [DW-1:0] out_q
);

  logic [DW-1:0] opnd;
  logic [DW-1:0] res;
  logic          res_c;
  logic [DW-1:0] acc_q;
  logic [DW-1:0] out_r;
  logic          carry_q;
  logic          zero_q;

  always_comb begin
    case (src)
      SRC_IMM:  opnd = imm;
      SRC_MEM:  opnd = mem_rd;
      SRC_PORT: opnd = port_in;
      default:  opnd = '0;
    endcase
  end

  nib_alu #(.W(DW)) u_alu (
    .a    (acc_q),
    .b    (opnd),
    .op   (alu_op),
    .y    (res),
    .cout (res_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      out_r   <= '0;
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      if (acc_ld)   acc_q   <= res;
      if (carry_ld) carry_q <= res_c;
      if (zero_ld)  zero_q  <= ~|res;
      if (out_ld)   out_r   <= acc_q;
    end
  end

  assign acc   = acc_q;
  assign carry = carry_q;
  assign zero  = zero_q;
  assign out_q = out_r;

  // a result that lands in the accumulator leaves zero consistent with it
  assert_zero_matches_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ld && zero_ld) |=> (zero_q == (acc_q == '0)));

  // the fetch clock never disturbs the accumulator
  assert_acc_hold_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !phase |=> $stable(acc_q));

  // output register only moves on an output load
  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ld |=> $stable(out_r));

endmodule

// File: rtl/nib_core.sv
module nib_core
  import nib_core_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int PROG_W = 8,
  parameter int ADDR_W = 12,
  localparam int HI_W  = ADDR_W - PROG_W,
  localparam int OPC_W = PROG_W - HI_W,
  localparam int UA_W  = OPC_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] prog_addr,
  input  logic [PROG_W-1:0] prog_data,
  output logic [UA_W-1:0]   uc_addr,
  input  logic [CTRL_W-1:0] uc_word,
  output logic [ADDR_W-1:0] dmem_addr,
  output logic [DATA_W-1:0] dmem_wdata,
  input  logic [DATA_W-1:0] dmem_rdata,
  output logic              dmem_ce_n,
  output logic              dmem_we_n,
  input  logic [DATA_W-1:0] in_port,
  output logic [DATA_W-1:0] out_port
);

  ctrl_t             ctrl;
  logic [PROG_W-1:0] fetch;
  logic              phase;
  logic              carry;
  logic              zero;
  logic [DATA_W-1:0] acc;

  assign ctrl = ctrl_t'(uc_word);

  nib_seq #(.PW(PROG_W), .AW(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_ld  (ctrl.fetch_ld),
    .pc_inc    (ctrl.pc_inc),
    .pc_ld     (ctrl.pc_ld),
    .prog_byte (prog_data),
    .pc        (prog_addr),
    .phase     (phase),
    .fetch     (fetch)
  );

  nib_datapath #(.DW(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .acc_ld   (ctrl.acc_ld),
    .zero_ld  (ctrl.zero_ld),
    .carry_ld (ctrl.carry_ld),
    .out_ld   (ctrl.out_ld),
    .alu_op   (ctrl.alu),
    .src      (ctrl.src),
    .imm      (fetch[DATA_W-1:0]),
    .mem_rd   (dmem_rdata),
    .port_in  (in_port),
    .acc      (acc),
    .carry    (carry),
    .zero     (zero),
    .out_q    (out_port)
  );

  assign uc_addr    = {fetch[PROG_W-1:HI_W], phase, carry, zero};
  assign dmem_addr  = {fetch[HI_W-1:0], prog_data};
  assign dmem_wdata = acc;
  // memory is live only in the low half of the clock
  assign dmem_ce_n  = ~ctrl.mem_en | clk;
  assign dmem_we_n  = ~ctrl.mem_wr;

  // write data held across the whole execute clock up to the committing edge
  assert_wdata_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase && ctrl.mem_wr) |-> $stable(acc));

endmodule

// File: tb/nib_core_bench.sv
module nib_core_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] prog_addr;
  logic [7:0]  prog_data;
  logic [6:0]  uc_addr;
  logic [12:0] uc_word;
  logic [11:0] dmem_addr;
  logic [3:0]  dmem_wdata;
  logic [3:0]  dmem_rdata;
  logic        dmem_ce_n;
  logic        dmem_we_n;
  logic [3:0]  in_port = 4'd0;
  logic [3:0]  out_port;

  logic [7:0]  prog  [4096];
  logic [3:0]  dmem  [4096];
  logic [3:0]  m_dm  [4096];
  logic [12:0] ucode [128];

  int n_checks = 0;
  int n_fail   = 0;

  // model state
  logic [11:0] m_pc;
  logic [3:0]  m_acc, m_out, m_op, m_wd;
  logic        m_c, m_z, pre_c, pre_z, exp_wr, exp_mem;
  logic [11:0] m_a;

  always #2 clk = ~clk;

  assign prog_data  = prog[prog_addr];
  assign dmem_rdata = dmem[dmem_addr];
  assign uc_word    = ucode[uc_addr];

  nib_core u_nib_core (
    .clk(clk), .rst_n(rst_n), .prog_addr(prog_addr), .prog_data(prog_data),
    .uc_addr(uc_addr), .uc_word(uc_word), .dmem_addr(dmem_addr),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .dmem_ce_n(dmem_ce_n),
    .dmem_we_n(dmem_we_n), .in_port(in_port), .out_port(out_port)
  );

  // control word generator; field positions as in R1, op codes as in R4, sources as in R10
  function automatic logic [12:0] uc_gen(int op, bit ph, bit c, bit z);
    int F = 1, PI = 2, PL = 4, AL = 8, ZL = 16, EN = 512, WR = 1024, OL = 2048, CL = 4096;
    int ADD = 1 << 5, SUB = 2 << 5, NOR = 3 << 5, MEM = 1 << 7, PRT = 2 << 7;
    int w;
    if (!ph) return 13'(F | PI);
    case (op)
      0:  w = AL | ZL;
      1:  w = AL | ZL | CL | ADD;
      2:  w = ZL | CL | SUB;
      3:  w = AL | ZL | NOR;
      4:  w = AL | ZL | MEM | EN | PI;
      5:  w = EN | WR | PI;
      6:  w = AL | ZL | CL | ADD | MEM | EN | PI;
      7:  w = ZL | CL | SUB | MEM | EN | PI;
      8:  w = AL | ZL | NOR | MEM | EN | PI;
      9:  w = AL | ZL | PRT;
      10: w = OL;
      11: w = PL;
      12: w = z ? PL : PI;
      13: w = !z ? PL : PI;
      14: w = c ? PL : PI;
      default: w = !c ? PL : PI;
    endcase
    return 13'(w);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string pc_tag(logic [3:0] op);
    if (op >= 4'd12) return "R5/R8";
    if (op == 4'd11) return "R8";
    if (op <= 4'd3 || op == 4'd9 || op == 4'd10) return "R7";
    return "R3/R2";
  endfunction

  task automatic alu_model(logic [3:0] b, int op, bit wr_acc, bit wr_c);
    logic [4:0] s;
    logic [3:0] r;
    case (op)
      1: s = {1'b0, m_acc} + {1'b0, b};
      2: s = {1'b0, m_acc} + {1'b0, ~b} + 5'd1;
      3: s = {1'b0, ~(m_acc | b)};
      default: s = {1'b0, b};
    endcase
    r = s[3:0];
    if (wr_c) m_c = s[4];
    m_z = (r == 4'd0);
    if (wr_acc) m_acc = r;
  endtask

  task automatic model_step();
    logic [7:0] b;
    logic [3:0] n;
    b = prog[m_pc];
    m_pc = m_pc + 12'd1;
    m_op = b[7:4];
    n = b[3:0];
    m_a = {n, prog[m_pc]};
    pre_c = m_c;
    pre_z = m_z;
    exp_wr = 1'b0;
    exp_mem = (m_op >= 4'd4 && m_op <= 4'd8);
    case (m_op)
      4'd0: alu_model(n, 0, 1, 0);
      4'd1: alu_model(n, 1, 1, 1);
      4'd2: alu_model(n, 2, 0, 1);
      4'd3: alu_model(n, 3, 1, 0);
      4'd4: alu_model(m_dm[m_a], 0, 1, 0);
      4'd5: begin exp_wr = 1'b1; m_wd = m_acc; m_dm[m_a] = m_acc; end
      4'd6: alu_model(m_dm[m_a], 1, 1, 1);
      4'd7: alu_model(m_dm[m_a], 2, 0, 1);
      4'd8: alu_model(m_dm[m_a], 3, 1, 0);
      4'd9: alu_model(in_port, 0, 1, 0);
      4'd10: m_out = m_acc;
      default: ;
    endcase
    if (exp_mem) m_pc = m_pc + 12'd1;
    else if (m_op == 4'd11) m_pc = m_a;
    else if (m_op >= 4'd12) begin
      bit take;
      case (m_op)
        4'd12: take = pre_z;
        4'd13: take = !pre_z;
        4'd14: take = pre_c;
        default: take = !pre_c;
      endcase
      m_pc = take ? m_a : m_pc + 12'd1;
    end
  endtask

  task automatic run_prog(int ncyc);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    m_pc = '0; m_acc = '0; m_out = '0; m_c = 1'b0; m_z = 1'b0; m_op = '0;
    rst_n = 1'b1;
    // R9: reset state seen right after release
    chk(prog_addr == 12'd0 && out_port == 4'd0 && uc_addr == 7'd0 && dmem_ce_n,
        "R9", "reset state", {prog_addr, out_port, uc_addr}, 0);
    for (int k = 0; k < ncyc; k++) begin
      if (k % 2 == 0) begin
        chk(prog_addr == m_pc, pc_tag(m_op), "pc", prog_addr, m_pc);
        chk(out_port == m_out, "R4/R10", "out_port", out_port, m_out);
        chk(uc_addr[2] == 1'b0, "R1", "phase bit fetch", uc_addr, 0);
        in_port = 4'($urandom);
        model_step();
      end else begin
        chk(uc_addr == {m_op, 1'b1, pre_c, pre_z}, "R1", "uc_addr exec",
            uc_addr, {m_op, 1'b1, pre_c, pre_z});
        chk(dmem_ce_n == !exp_mem, "R6", "ce_n exec", dmem_ce_n, !exp_mem);
        if (exp_mem)
          chk(dmem_addr == m_a, "R3", "dmem_addr", dmem_addr, m_a);
        if (!dmem_ce_n && !dmem_we_n) begin
          chk(exp_wr && dmem_wdata == m_wd, "R6", "write data", dmem_wdata, m_wd);
          dmem[dmem_addr] = dmem_wdata;
        end else begin
          chk(!exp_wr, "R6", "missing write", 0, 1);
        end
      end
      @(posedge clk);
      #1;
      chk(dmem_ce_n == 1'b1, "R6", "ce_n with clock high", dmem_ce_n, 1);
      @(negedge clk);
    end
  endtask

  task automatic load_mem(bit rnd);
    for (int i = 0; i < 4096; i++) begin
      prog[i] = rnd ? 8'($urandom) : 8'h00;
      dmem[i] = rnd ? 4'($urandom) : 4'h0;
      m_dm[i] = dmem[i];
    end
  endtask

  initial begin
    void'($urandom(32'h1D5E_0C4B));
    for (int i = 0; i < 128; i++)
      ucode[i] = uc_gen(i >> 3, i[2], i[1], i[0]);

    // directed: 0+15 stored and read back, compare, carry wrap, jump near top of space
    load_mem(1'b0);
    prog[12'h000] = 8'h00;                          // LIT 0
    prog[12'h001] = 8'h1F;                          // ADDI 15
    prog[12'h002] = 8'h50; prog[12'h003] = 8'h38;   // ST 038
    prog[12'h004] = 8'h40; prog[12'h005] = 8'h38;   // LD 038
    prog[12'h006] = 8'hA0;                          // OUT
    prog[12'h007] = 8'h2F;                          // CMPI 15
    prog[12'h008] = 8'hC0; prog[12'h009] = 8'h10;   // JZ 010
    prog[12'h010] = 8'h11;                          // ADDI 1 -> 0, carry
    prog[12'h011] = 8'hA0;                          // OUT
    prog[12'h012] = 8'hFF; prog[12'h013] = 8'hFE;   // JNC FFE (not taken)
    prog[12'h014] = 8'hBF; prog[12'h015] = 8'hFE;   // JMP FFE
    prog[12'hFFE] = 8'h30;                          // NORI 0 -> 15
    prog[12'hFFF] = 8'hA0;                          // OUT, then PC wraps to 0
    run_prog(120);

    // random programs
    for (int p = 0; p < 12; p++) begin
      load_mem(1'b1);
      run_prog(1400);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL R2 watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule